// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds the two 16-bit data pointers of an 8051-style core, together with the configuration state that controls how they are used. The core's decoder reports an instruction class each cycle, along with a flag that says whether the instruction names the primary or the alternate pointer reference. The block returns the effective address taken from the chosen pointer. It also reports whether a code-memory access goes to the signature array instead of code memory, and whether an external data move exchanges its byte with the B register instead of the accumulator.

Each pointer has its own post-access auto-update enable and its own direction bit. The direction bit also reverses the pointer increment instruction. A select bit swaps which physical pointer answers the primary and the alternate references. Software writes to a pointer's high or low byte arrive on a separate port. In the same cycle they take priority over any change the instruction would make to that pointer.

Top module: `dual_dptr_unit`

## Requirements
- R1: After reset both pointers read 0000h, the configuration byte reads 00h and the B-redirect flag reads 0.
- R2: Configuration bit layout: bit 7 auto-update enable of pointer 1, bit 6 auto-update enable of pointer 0, bit 5 direction of pointer 1, bit 4 direction of pointer 0, bit 3 signature enable, bit 2 pointer select. Bits 1 and 0 always read 0. A configuration write takes effect from the next cycle.
- R3: The referenced pointer is pointer `select XOR op_alt`: with select 0 the primary reference is pointer 0 and the alternate is pointer 1, and with select 1 they swap. `eff_addr` always shows the referenced pointer's current value.
- R4: For op_code 1 (external data move) or op_code 2 (code read), the referenced pointer is updated at the end of the cycle when its auto-update enable is set. It is incremented when its direction bit is 0 and decremented when it is 1. The address presented in that cycle is the value before the update. With the enable clear the pointer is unchanged.
- R5: op_code 3 (pointer increment) increments the referenced pointer when its direction bit is 0 and decrements it when the bit is 1, whatever the auto-update enable.
- R6: Pointer arithmetic wraps modulo 2^16: FFFFh+1 gives 0000h and 0000h-1 gives FFFFh.
- R7: `mem_sig` is 1 exactly when signature enable is set and either op_code is 2 or `iap_req` is 1.
- R8: `use_b` is 1 exactly when op_code is 1, the B-redirect flag is set and the referenced pointer is pointer 1. Moves through pointer 0 and code reads use the accumulator.
- R9: op_code 4 (pointer load) writes `load_value` into the referenced pointer.
- R10: A byte write (`ptr_we`) to pointer `ptr_idx` replaces its high byte (`ptr_hi`=1) or low byte (`ptr_hi`=0) and keeps the other byte. Any change the same cycle's instruction would make to that pointer is discarded.
- R11: op_code 0, and the unused codes 5 to 7, leave both pointers unchanged. An instruction changes only the pointer it references.
- R12: `mode_we` loads `redir_wdata` into the B-redirect flag, readable on `redir_b` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Instruction class: 0 none, 1 external move, 2 code read, 3 increment, 4 load |
| op_alt | input | 1 | 1 when the instruction uses the alternate reference |
| load_value | input | 16 | Value for a pointer load |
| iap_req | input | 1 | In-application programming access this cycle |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| mode_we | input | 1 | B-redirect flag write strobe |
| redir_wdata | input | 1 | B-redirect flag write data |
| ptr_we | input | 1 | Pointer byte write strobe |
| ptr_idx | input | 1 | Physical pointer written by the byte write |
| ptr_hi | input | 1 | 1 writes the high byte, 0 the low byte |
| ptr_wdata | input | 8 | Byte write data |
| eff_addr | output | 16 | Effective address from the referenced pointer |
| mem_sig | output | 1 | Code-space access targets the signature array |
| use_b | output | 1 | External move uses B instead of the accumulator |
| cfg_rdata | output | 8 | Configuration byte read-back |
| redir_b | output | 1 | B-redirect flag read-back |
| ptr0_q | output | 16 | Pointer 0 |
| ptr1_q | output | 16 | Pointer 1 |

## Verification
Random instruction streams run under constantly changing configuration bytes. They separate the four select and direction combinations per pointer, and show that an instruction touches only its referenced pointer. Directed sweeps walk every pairing of select, redirect, reference and instruction class. They show that B replaces the accumulator only for external moves through pointer 1, and that the signature flag follows code reads and programming requests only. Pointers parked at FFFFh and 0000h are stepped both ways to expose wrap errors. Byte writes landing in the same cycle as an update separate "byte write wins" from "update wins" and from "both apply".

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_XMOVE = 3'd1,
    OP_CREAD = 3'd2,
    OP_PINC  = 3'd3,
    OP_LOAD  = 3'd4
  } dptr_op_e;

  // configuration bit positions (decoded by the core's software)
  localparam int unsigned CFG_UPD1 = 7;
  localparam int unsigned CFG_UPD0 = 6;
  localparam int unsigned CFG_DEC1 = 5;
  localparam int unsigned CFG_DEC0 = 4;
  localparam int unsigned CFG_SIG  = 3;
  localparam int unsigned CFG_SEL  = 2;
  localparam logic [7:0] CFG_WMASK = 8'hFC;

  localparam int unsigned NPTR = 2;

endpackage

// File: rtl/dptr_cfg_reg.sv
module dptr_cfg_reg
  import dptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       mode_we,
  input  logic       redir_wdata,
  output logic [7:0] cfg_q,
  output logic       redir_q,
  output logic [NPTR-1:0] upd_en,
  output logic [NPTR-1:0] dec_en,
  output logic       sig_en,
  output logic       sel
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= 8'h00;
      redir_q <= 1'b0;
    end else begin
      if (cfg_we)  cfg_q   <= cfg_wdata & CFG_WMASK;
      if (mode_we) redir_q <= redir_wdata;
    end
  end

  assign upd_en = {cfg_q[CFG_UPD1], cfg_q[CFG_UPD0]};
  assign dec_en = {cfg_q[CFG_DEC1], cfg_q[CFG_DEC0]};
  assign sig_en = cfg_q[CFG_SIG];
  assign sel    = cfg_q[CFG_SEL];

endmodule

// File: rtl/dptr_route.sv
module dptr_route
  import dptr_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [2:0]    op_code,
  input  logic          op_alt,
  input  logic          sel,
  input  logic          sig_en,
  input  logic          redir,
  input  logic          iap_req,
  input  logic [AW-1:0] p0,
  input  logic [AW-1:0] p1,
  output logic          ref_idx,
  output logic [AW-1:0] eff_addr,
  output logic          is_access,
  output logic          is_inc,
  output logic          is_load,
  output logic          use_b,
  output logic          mem_sig
);

  dptr_op_e op;

  always_comb begin
    case (op_code)
      3'd1:    op = OP_XMOVE;
      3'd2:    op = OP_CREAD;
      3'd3:    op = OP_PINC;
      3'd4:    op = OP_LOAD;
      default: op = OP_NONE;
    endcase
  end

  assign ref_idx   = sel ^ op_alt;
  assign eff_addr  = ref_idx ? p1 : p0;
  assign is_access = (op == OP_XMOVE) || (op == OP_CREAD);
  assign is_inc    = (op == OP_PINC);
  assign is_load   = (op == OP_LOAD);
  assign use_b     = (op == OP_XMOVE) && redir && ref_idx;
  assign mem_sig   = sig_en && ((op == OP_CREAD) || iap_req);

endmodule

// File: rtl/dptr_reg.sv
module dptr_reg #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          step_dec,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          bwe,
  input  logic          bhi,
  input  logic [7:0]    bdata,
  output logic [AW-1:0] q,
  output logic          stepped
);

  localparam int unsigned HW = AW - 8;

  function automatic logic [AW-1:0] step_val(input logic [AW-1:0] v, input logic dn);
    return dn ? v - AW'(1) : v + AW'(1);
  endfunction

  logic [AW-1:0] q_next;

  always_comb begin
    q_next = q;
    if (bwe) begin
      if (bhi) q_next[AW-1:8] = HW'(bdata);
      else     q_next[7:0]    = bdata;
    end else if (load_en) begin
      q_next = load_val;
    end else if (step_en) begin
      q_next = step_val(q, step_dec);
    end
  end

  assign stepped = step_en && !bwe && !load_en;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dptr_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_code,
  input  logic          op_alt,
  input  logic [AW-1:0] load_value,
  input  logic          iap_req,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          mode_we,
  input  logic          redir_wdata,
  input  logic          ptr_we,
  input  logic          ptr_idx,
  input  logic          ptr_hi,
  input  logic [7:0]    ptr_wdata,
  output logic [AW-1:0] eff_addr,
  output logic          mem_sig,
  output logic          use_b,
  output logic [7:0]    cfg_rdata,
  output logic          redir_b,
  output logic [AW-1:0] ptr0_q,
  output logic [AW-1:0] ptr1_q
);

  logic [NPTR-1:0] upd_en, dec_en;
  logic            sig_en, sel;
  logic            ref_idx, is_access, is_inc, is_load;
  logic [AW-1:0]   ptr_q [NPTR];
  logic [NPTR-1:0] step_fire;

  dptr_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_we(mode_we), .redir_wdata(redir_wdata),
    .cfg_q(cfg_rdata), .redir_q(redir_b),
    .upd_en(upd_en), .dec_en(dec_en), .sig_en(sig_en), .sel(sel)
  );

  dptr_route #(.AW(AW)) u_route (
    .op_code(op_code), .op_alt(op_alt), .sel(sel), .sig_en(sig_en),
    .redir(redir_b), .iap_req(iap_req),
    .p0(ptr_q[0]), .p1(ptr_q[1]),
    .ref_idx(ref_idx), .eff_addr(eff_addr),
    .is_access(is_access), .is_inc(is_inc), .is_load(is_load),
    .use_b(use_b), .mem_sig(mem_sig)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic hit;
    assign hit = (ref_idx == 1'(i));
    dptr_reg #(.AW(AW)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .step_en(hit && ((is_access && upd_en[i]) || is_inc)),
      .step_dec(dec_en[i]),
      .load_en(hit && is_load),
      .load_val(load_value),
      .bwe(ptr_we && (ptr_idx == 1'(i))),
      .bhi(ptr_hi),
      .bdata(ptr_wdata),
      .q(ptr_q[i]),
      .stepped(step_fire[i])
    );
  end

  assign ptr0_q = ptr_q[0];
  assign ptr1_q = ptr_q[1];

endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_code,
  input logic          op_alt,
  input logic          ptr_we,
  input logic          ptr_idx,
  input logic          ptr_hi,
  input logic [7:0]    ptr_wdata,
  input logic [AW-1:0] eff_addr,
  input logic          mem_sig,
  input logic          use_b,
  input logic [7:0]    cfg_rdata,
  input logic [AW-1:0] ptr0_q,
  input logic [AW-1:0] ptr1_q,
  input logic [1:0]    step_fire
);

  logic ref1;
  assign ref1 = cfg_rdata[2] ^ op_alt;

  p_cfg_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[1:0] == 2'b00);

  p_eff_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eff_addr == (ref1 ? ptr1_q : ptr0_q));

  p_post_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_code == 3'd1 || op_code == 3'd2) && !ref1 && cfg_rdata[6] && !cfg_rdata[4]
      && !(ptr_we && !ptr_idx))
    |=> ptr0_q == $past(ptr0_q) + AW'(1));

  p_inc_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd3 && ref1 && !cfg_rdata[5] && ptr1_q == '1 && !(ptr_we && ptr_idx))
    |=> ptr1_q == '0);

  p_sig_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sig |-> cfg_rdata[3]);

  p_useb_ptr1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    use_b |-> (eff_addr == ptr1_q && op_code == 3'd1));

  p_byte_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && !ptr_idx && !ptr_hi) |=> ptr0_q[7:0] == $past(ptr_wdata));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0 && !ptr_we) |=> ($stable(ptr0_q) && $stable(ptr1_q)));

  p_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_fire));

endmodule

bind dual_dptr_unit dptr_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_alt(op_alt),
  .ptr_we(ptr_we), .ptr_idx(ptr_idx), .ptr_hi(ptr_hi), .ptr_wdata(ptr_wdata),
  .eff_addr(eff_addr), .mem_sig(mem_sig), .use_b(use_b), .cfg_rdata(cfg_rdata),
  .ptr0_q(ptr0_q), .ptr1_q(ptr1_q), .step_fire(step_fire)
);

// File: tb/sim_dual_dptr_unit.sv
module sim_dual_dptr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic        op_alt = 1'b0;
  logic [15:0] load_value = 16'h0;
  logic        iap_req = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h0;
  logic        mode_we = 1'b0;
  logic        redir_wdata = 1'b0;
  logic        ptr_we = 1'b0;
  logic        ptr_idx = 1'b0;
  logic        ptr_hi = 1'b0;
  logic [7:0]  ptr_wdata = 8'h0;
  logic [15:0] eff_addr, ptr0_q, ptr1_q;
  logic        mem_sig, use_b, redir_b;
  logic [7:0]  cfg_rdata;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  // reference state
  logic [15:0] m_p [2];
  logic [7:0]  m_cfg;
  logic        m_redir;

  always #2 clk = ~clk;

  dual_dptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_alt(op_alt),
    .load_value(load_value), .iap_req(iap_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_we(mode_we), .redir_wdata(redir_wdata), .ptr_we(ptr_we), .ptr_idx(ptr_idx),
    .ptr_hi(ptr_hi), .ptr_wdata(ptr_wdata), .eff_addr(eff_addr), .mem_sig(mem_sig),
    .use_b(use_b), .cfg_rdata(cfg_rdata), .redir_b(redir_b), .ptr0_q(ptr0_q), .ptr1_q(ptr1_q)
  );

  function automatic logic [15:0] bump(input logic [15:0] v, input logic down);
    logic [16:0] t;
    t = down ? {1'b0, v} + 17'h1FFFF : {1'b0, v} + 17'd1;
    return t[15:0];
  endfunction

  function automatic logic exp_ref();
    return m_cfg[2] ^ op_alt;
  endfunction

  function automatic logic exp_sig();
    return m_cfg[3] && (op_code == 3'd2 || iap_req);
  endfunction

  function automatic logic exp_useb();
    return op_code == 3'd1 && m_redir && exp_ref();
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic r;
    logic [15:0] np [2];
    r = exp_ref();
    np[0] = m_p[0];
    np[1] = m_p[1];
    case (op_code)
      3'd1, 3'd2: if (m_cfg[6 + r]) np[r] = bump(m_p[r], m_cfg[4 + r]);
      3'd3:       np[r] = bump(m_p[r], m_cfg[4 + r]);
      3'd4:       np[r] = load_value;
      default:    ;
    endcase
    if (ptr_we) begin
      np[ptr_idx] = m_p[ptr_idx];
      if (ptr_hi) np[ptr_idx][15:8] = ptr_wdata;
      else        np[ptr_idx][7:0]  = ptr_wdata;
    end
    m_p[0] = np[0];
    m_p[1] = np[1];
    if (cfg_we)  m_cfg = {cfg_wdata[7:2], 2'b00};
    if (mode_we) m_redir = redir_wdata;
  endtask

  // inputs already driven after a negedge: check outputs, clock, check state
  task automatic run_cycle();
    #1;
    check("R3 eff_addr", eff_addr, m_p[exp_ref()]);
    check("R7 mem_sig", {15'd0, mem_sig}, {15'd0, exp_sig()});
    check("R8 use_b", {15'd0, use_b}, {15'd0, exp_useb()});
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R4 R5 R6 R9 R10 R11 ptr0", ptr0_q, m_p[0]);
    check("R4 R5 R6 R9 R10 R11 ptr1", ptr1_q, m_p[1]);
    check("R2 cfg", {8'd0, cfg_rdata}, {8'd0, m_cfg});
    check("R12 redir", {15'd0, redir_b}, {15'd0, m_redir});
  endtask

  task automatic quiet();
    op_code = 3'd0; op_alt = 1'b0; iap_req = 1'b0; cfg_we = 1'b0;
    mode_we = 1'b0; ptr_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [7:0] v);
    quiet(); cfg_we = 1'b1; cfg_wdata = v; run_cycle();
  endtask

  task automatic load(input logic alt, input logic [15:0] v);
    quiet(); op_code = 3'd4; op_alt = alt; load_value = v; run_cycle();
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_p[0] = 16'h0; m_p[1] = 16'h0; m_cfg = 8'h0; m_redir = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ptr0", ptr0_q, 16'h0000);
    check("R1 ptr1", ptr1_q, 16'h0000);
    check("R1 cfg", {8'd0, cfg_rdata}, 16'h0000);
    check("R1 redir", {15'd0, redir_b}, 16'h0000);

    // R2 reserved bits read 0
    set_cfg(8'hFF);
    check("R2 low bits masked", {8'd0, cfg_rdata}, 16'h00FC);

    // R6 wrap: pointer0 at FFFF incremented by auto-update, pointer1 at 0000 decremented by INC
    set_cfg(8'h40);                 // upd0, dec0=0, sel=0
    load(1'b0, 16'hFFFF);
    quiet(); op_code = 3'd1; run_cycle();
    check("R6 inc wrap", ptr0_q, 16'h0000);
    set_cfg(8'h20);                 // dec1=1
    load(1'b1, 16'h0000);
    quiet(); op_code = 3'd3; op_alt = 1'b1; run_cycle();
    check("R6 dec wrap", ptr1_q, 16'hFFFF);
    // R5 INC ignores update enable (cfg has upd1=0 here, pointer1 still moved)

    // R4 update disabled: code read leaves pointer unchanged
    set_cfg(8'h00);
    load(1'b0, 16'h1234);
    quiet(); op_code = 3'd2; run_cycle();
    check("R4 no update when disabled", ptr0_q, 16'h1234);

    // R10 byte write beats auto-update in the same cycle
    set_cfg(8'h40);
    quiet(); op_code = 3'd1; ptr_we = 1'b1; ptr_idx = 1'b0; ptr_hi = 1'b1; ptr_wdata = 8'hAB;
    run_cycle();
    check("R10 byte wins", ptr0_q, 16'hAB34);

    // R8/R3 sweep over select, redirect, alternate and class
    for (int s = 0; s < 2; s++)
      for (int rd = 0; rd < 2; rd++) begin
        quiet(); cfg_we = 1'b1; cfg_wdata = s[0] ? 8'h04 : 8'h00;
        mode_we = 1'b1; redir_wdata = rd[0]; run_cycle();
        for (int a = 0; a < 2; a++)
          for (int c = 0; c < 6; c++) begin
            quiet(); op_code = 3'(c); op_alt = a[0]; iap_req = c[0]; run_cycle();
          end
      end

    // random mix
    for (int n = 0; n < 6000; n++) begin
      quiet();
      op_code    = 3'($urandom % 6);
      op_alt     = 1'($urandom);
      load_value = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
      iap_req    = 1'($urandom % 4 == 0);
      cfg_we     = ($urandom % 8 == 0);
      cfg_wdata  = 8'($urandom);
      mode_we    = ($urandom % 8 == 0);
      redir_wdata = 1'($urandom);
      ptr_we     = ($urandom % 10 == 0);
      ptr_idx    = 1'($urandom);
      ptr_hi     = 1'($urandom);
      ptr_wdata  = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      run_cycle();
    end

    quiet();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule